// File: doc/BRIEF.md
# Multi-Cycle Signed/Unsigned Integer Divider

This block divides a double-width dividend by a single-width divisor and returns a single-width quotient and remainder. The dividend arrives as a high half and a low half, each `W` bits wide, and is read as `{hi, lo}`. A per-request mode input chooses unsigned or two's-complement signed operation. Results truncate toward zero.

A request is taken by pulsing `start` while the unit is idle. The unit raises `busy` until it finishes, then pulses `done` for one cycle. The quotient may not fit in `W` bits, and the divisor may be zero. In either case the unit raises `div_err` together with `done` and keeps its previous quotient and remainder. No other status is produced.

The core works on magnitudes and uses restoring division, one quotient bit per clock. Before iterating it screens out any request whose quotient cannot fit. After iterating it applies the signs and, in signed mode, checks the quotient against the signed range.

Top module: `int_divider`

## Requirements
- R1: In unsigned mode (`signed_mode`=0), with D = {dvd_hi, dvd_lo} and d = `divisor` both taken as unsigned, a non-error result gives `quot` = floor(D/d) and `rem` = D − quot·d, where `rem` < d.
- R2: In signed mode (`signed_mode`=1), D (2W bits) and d (W bits) are two's complement. The quotient truncates toward zero. A nonzero `rem` has the sign of D, and |rem| < |d|.
- R3: A zero divisor makes `div_err` high in the `done` cycle, in either mode.
- R4: In unsigned mode, a quotient above 2^W − 1 makes `div_err` high in the `done` cycle.
- R5: In signed mode, a quotient outside −2^(W−1) … 2^(W−1) − 1 makes `div_err` high. This covers the case of a most-negative value divided by −1.
- R6: When `div_err` is high, `quot` and `rem` keep the values they held before the request.
- R7: Let edge 0 be the edge that accepts `start`. For a zero divisor, or a quotient whose magnitude is at least 2^W, `done` is high after edge 1. For every other request `done` is high after edge W+2. `done` stays high for exactly one cycle.
- R8: `busy` is high from the accepting edge until `done` is raised. A `start` seen while `busy` is high is ignored, and the result belongs to the request that was accepted first.
- R9: After reset, `busy`, `done`, `div_err`, `quot` and `rem` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| signed_mode | input | 1 | 1 = signed division, 0 = unsigned |
| dvd_hi | input | W | Upper half of the dividend |
| dvd_lo | input | W | Lower half of the dividend |
| divisor | input | W | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error (zero divisor or quotient out of range), valid with done |
| quot | output | W | Quotient |
| rem | output | W | Remainder |

## Verification
The hardest case to reach is a signed quotient that exceeds the signed range by exactly one, for example the most-negative W-bit dividend divided by −1. This case passes the magnitude pre-screen, so only the range check at the end of the full iteration can catch it. Random stimulus almost never produces it. The bench therefore drives it directly, alongside the neighbouring legal case that yields exactly −2^(W−1). The latency in each case tells which of the two error paths fired. Random operands are shaped so that the high half is a sign extension of the low half or lies below the divisor. This keeps legal results frequent and still leaves many overflow cases.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RUN,
    ST_FIX
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes, result signs and the pre-iteration screen.
module div_prep #(
  parameter int W = 32
) (
  input  logic         signed_mode,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] mag_hi,
  output logic [W-1:0] mag_lo,
  output logic [W-1:0] mag_dvs,
  output logic         q_neg,
  output logic         r_neg,
  output logic         pre_err
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dvd_full;
  logic [DW-1:0] dvd_mag;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    dvd_full = {hi, lo};
    dvd_neg  = signed_mode & hi[W-1];
    dvs_neg  = signed_mode & dvs[W-1];
    dvd_mag  = dvd_neg ? -dvd_full : dvd_full;
    mag_dvs  = dvs_neg ? -dvs : dvs;
    mag_hi   = dvd_mag[DW-1:W];
    mag_lo   = dvd_mag[W-1:0];
    q_neg    = dvd_neg ^ dvs_neg;
    r_neg    = dvd_neg;
    // Quotient magnitude >= 2^W whenever upper magnitude reaches the divisor.
    pre_err  = (dvs == '0) | (mag_hi >= mag_dvs);
  end
endmodule

// File: rtl/div_iter.sv
// Restoring division on magnitudes, one quotient bit per enabled cycle.
module div_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] in_hi,
  input  logic [W-1:0] in_lo,
  input  logic [W-1:0] in_dvs,
  output logic [W-1:0] mag_q,
  output logic [W-1:0] mag_r,
  output logic         last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  part_r;
  logic [W-1:0]  shift_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          fits;

  always_comb begin
    trial = {part_r, shift_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = trial >= {1'b0, dvs_q};
    last  = (cnt == CW'(W - 1));
    mag_q = shift_q;
    mag_r = part_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part_r  <= '0;
      shift_q <= '0;
      dvs_q   <= '0;
      cnt     <= '0;
    end else if (load) begin
      part_r  <= in_hi;
      shift_q <= in_lo;
      dvs_q   <= in_dvs;
      cnt     <= '0;
    end else if (en) begin
      part_r  <= fits ? diff[W-1:0] : trial[W-1:0];
      shift_q <= {shift_q[W-2:0], fits};
      cnt     <= cnt + CW'(1);
    end
  end

  // Partial remainder stays below the divisor throughout the iteration (R1, R2).
  p_partial_below_divisor_r1: assert property (@(posedge clk) disable iff (rst)
    en |-> (part_r < dvs_q));
endmodule

// File: rtl/div_fix.sv
// Sign application and signed-range check on the finished magnitudes.
module div_fix #(
  parameter int W = 32
) (
  input  logic         signed_mode,
  input  logic         q_neg,
  input  logic         r_neg,
  input  logic [W-1:0] mag_q,
  input  logic [W-1:0] mag_r,
  output logic [W-1:0] quo,
  output logic [W-1:0] rmd,
  output logic         range_err
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    quo       = q_neg ? -mag_q : mag_q;
    rmd       = r_neg ? -mag_r : mag_r;
    range_err = signed_mode & (q_neg ? (mag_q > HALF) : (mag_q >= HALF));
  end
endmodule

// File: rtl/int_divider.sv
module int_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  import div_pkg::*;

  div_state_e   state;
  logic [W-1:0] op_hi, op_lo, op_dvs;
  logic         op_sgn;
  logic [W-1:0] quot_q, rem_q;
  logic         done_q, err_q;

  logic [W-1:0] m_hi, m_lo, m_dvs;
  logic         q_neg, r_neg, pre_err;
  logic [W-1:0] it_q, it_r;
  logic         it_last;
  logic [W-1:0] f_q, f_r;
  logic         range_err;
  logic         core_load, core_en;

  div_prep #(.W(W)) u_prep (
    .signed_mode(op_sgn), .hi(op_hi), .lo(op_lo), .dvs(op_dvs),
    .mag_hi(m_hi), .mag_lo(m_lo), .mag_dvs(m_dvs),
    .q_neg(q_neg), .r_neg(r_neg), .pre_err(pre_err)
  );

  assign core_load = (state == ST_CHECK) && !pre_err;
  assign core_en   = (state == ST_RUN);

  div_iter #(.W(W)) u_iter (
    .clk(clk), .rst(rst), .load(core_load), .en(core_en),
    .in_hi(m_hi), .in_lo(m_lo), .in_dvs(m_dvs),
    .mag_q(it_q), .mag_r(it_r), .last(it_last)
  );

  div_fix #(.W(W)) u_fix (
    .signed_mode(op_sgn), .q_neg(q_neg), .r_neg(r_neg),
    .mag_q(it_q), .mag_r(it_r),
    .quo(f_q), .rmd(f_r), .range_err(range_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_hi  <= '0;
      op_lo  <= '0;
      op_dvs <= '0;
      op_sgn <= 1'b0;
      quot_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          op_hi  <= dvd_hi;
          op_lo  <= dvd_lo;
          op_dvs <= divisor;
          op_sgn <= signed_mode;
          state  <= ST_CHECK;
        end
        ST_CHECK: if (pre_err) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
          state  <= ST_IDLE;
        end else begin
          state <= ST_RUN;
        end
        ST_RUN: if (it_last) state <= ST_FIX;
        ST_FIX: begin
          done_q <= 1'b1;
          if (range_err) begin
            err_q <= 1'b1;
          end else begin
            quot_q <= f_q;
            rem_q  <= f_r;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign div_err = err_q;
  assign quot    = quot_q;
  assign rem     = rem_q;

  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_hi) && $stable(op_lo) && $stable(op_dvs) && $stable(op_sgn)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_err_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (done && div_err) |-> ($stable(quot) && $stable(rem)));
  p_zero_divisor_r3: assert property (@(posedge clk) disable iff (rst)
    (done && (op_dvs == '0)) |-> div_err);
  p_unsigned_rem_r1: assert property (@(posedge clk) disable iff (rst)
    (done && !div_err && !op_sgn) |-> (rem < op_dvs));
  p_signed_rem_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !div_err && op_sgn && (rem != '0)) |-> (rem[W-1] == op_hi[W-1]));
endmodule

// File: tb/int_divider_bench.sv
`timescale 1ns/1ps
module int_divider_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic         busy, done, div_err;
  logic [W-1:0] quot, rem;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] prev_q = '0, prev_r = '0;

  always #2 clk = ~clk;

  int_divider #(.W(W)) u_int_divider (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .busy(busy), .done(done), .div_err(div_err), .quot(quot), .rem(rem)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model built from R1..R5 and R7.
  function automatic void model(input logic sm, input logic [W-1:0] hi, lo, d,
                                output logic err, output logic pre,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    longint dd, dv, qq, rr, lim, aq;
    lim = longint'(1) << (W - 1);
    if (sm) begin
      dd = longint'(signed'({hi, lo}));
      dv = longint'(signed'(d));
    end else begin
      dd = longint'({hi, lo});
      dv = longint'(d);
    end
    q = '0; r = '0;
    if (d == '0) begin
      err = 1'b1; pre = 1'b1;
    end else begin
      qq = dd / dv;
      rr = dd % dv;
      aq = (qq < 0) ? -qq : qq;
      pre = (aq >= (longint'(1) << W));
      if (sm) err = (qq < -lim) || (qq > lim - 1);
      else    err = (qq > (longint'(1) << W) - 1);
      q = qq[W-1:0];
      r = rr[W-1:0];
    end
  endfunction

  task automatic run_div(input logic sm, input logic [W-1:0] hi, lo, d,
                         input string req, input bit poke);
    logic exp_err, exp_pre;
    logic [W-1:0] eq, er;
    int k;
    model(sm, hi, lo, d, exp_err, exp_pre, eq, er);
    @(negedge clk);
    while (busy) @(negedge clk);
    signed_mode = sm; dvd_hi = hi; dvd_lo = lo; divisor = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < W + 10) begin
      if (poke && k == 2) begin
        chk(busy == 1'b1, "R8 busy", longint'(busy), 1);
        signed_mode = ~sm; dvd_hi = '0; dvd_lo = 16'h0005; divisor = 16'h0001; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == (exp_pre ? 1 : W + 2), {req, " R7 latency"}, longint'(k), exp_pre ? 1 : W + 2);
    chk(div_err == exp_err, {req, " err"}, longint'(div_err), longint'(exp_err));
    if (exp_err) begin
      chk(quot == prev_q && rem == prev_r, {req, " R6 hold"}, longint'({quot, rem}), longint'({prev_q, prev_r}));
    end else begin
      chk(quot == eq && rem == er, req, longint'({quot, rem}), longint'({eq, er}));
      prev_q = eq; prev_r = er;
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 pulse", longint'(done), 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] hi, lo, d;
    logic sm;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, div_err} == 3'b000 && quot == '0 && rem == '0, "R9 reset",
        longint'({busy, done, div_err}), 0);

    run_div(1'b0, 16'h0000, 16'd1000, 16'd7, "R1 small", 1'b0);
    run_div(1'b0, 16'hFFFE, 16'hFFFF, 16'hFFFF, "R1 max quotient", 1'b0);
    run_div(1'b0, 16'h0123, 16'h4567, 16'h0000, "R3 unsigned zero", 1'b0);
    run_div(1'b1, 16'hFFFF, 16'hFFF0, 16'h0000, "R3 signed zero", 1'b0);
    run_div(1'b0, 16'h0040, 16'h0000, 16'h0040, "R4 hi equals divisor", 1'b0);
    run_div(1'b1, 16'hFFFF, 16'hFFF9, 16'h0002, "R2 neg/pos", 1'b0);
    run_div(1'b1, 16'h0000, 16'h0007, 16'hFFFE, "R2 pos/neg", 1'b0);
    run_div(1'b1, 16'hFFFF, 16'hFFF9, 16'hFFFE, "R2 neg/neg", 1'b0);
    run_div(1'b1, 16'hFFFF, 16'h8000, 16'hFFFF, "R5 min/-1", 1'b0);
    run_div(1'b1, 16'hFFFF, 16'h8000, 16'h0001, "R5 min/1 legal", 1'b0);
    run_div(1'b1, 16'h0000, 16'h8000, 16'hFFFF, "R5 -min legal", 1'b0);
    run_div(1'b1, 16'h0000, 16'h8000, 16'h0001, "R5 +2^(W-1)", 1'b0);
    run_div(1'b1, 16'h8000, 16'h0000, 16'hFFFF, "R5 wide min", 1'b0);
    run_div(1'b0, 16'h0001, 16'h2345, 16'h0FFF, "R8 ignore start", 1'b1);

    for (int i = 0; i < 400; i++) begin
      sm = 1'($urandom);
      d  = W'($urandom);
      lo = W'($urandom);
      if (($urandom % 10) == 0) d = '0;
      case ($urandom % 4)
        0: hi = W'($urandom);
        1: hi = {W{lo[W-1]}};
        default: hi = (d == '0) ? '0 : W'($urandom % {16'd0, (sm ? 16'h7FFF & d : d)} );
      endcase
      run_div(sm, hi, lo, d, sm ? "R2 random" : "R1 random", 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule